// File: doc/BRIEF.md
# Cycle-Stealing DMA Block Mover

This block is a bus-master engine that copies a block of words between one device port and system memory while the processor is busy elsewhere. Software programs a transfer direction, a device address, a first memory address and a word count through a small register window, then sets a go bit. The engine takes no bus cycles until it asks for the bus and is granted it.

Each word costs one full request/grant exchange. The engine raises its request and waits for the grant. It moves exactly one word, then drops the request for at least one cycle so the processor gets the bus back. After every word the memory address advances by one word and the remaining count falls by one. When the count runs out, the engine goes idle and sets a done flag, which drives the interrupt line until software writes the status register.

Top module: `dma_steal_engine`

## Requirements
- R1: After reset the engine is idle: bus_req, mem_en, dev_rd, dev_wr and irq are 0, and every readable register reads 0.
- R2: Register window (reg_sel): 0 control (bit 0 go, bit 1 direction, read back at bit 1), 1 device address, 2 memory address, 3 remaining count, 4 status (bit 0 busy, bit 1 done). While idle, writes to selects 0 to 3 load the register. A read returns the current value in the same cycle.
- R3: A go write while idle with a nonzero count sets busy and raises bus_req on the next cycle. No word moves until bus_gnt has been seen high on a clock edge while bus_req is high.
- R4: One cycle after the grant edge, the engine drives a single one-cycle transfer with mem_en high. Direction 0 moves device to memory (dev_rd and mem_we high, mem_wdata = dev_rdata). Direction 1 moves memory to device (mem_we low, dev_wr high, dev_wdata = mem_rdata).
- R5: After every word that is not the last, bus_req is low for exactly one cycle before it is raised again.
- R6: Each word goes to the current memory address. After the word, the address has grown by 4 and the count has shrunk by 1.
- R7: The edge that moves the last word clears busy and sets done, and irq goes high together with done.
- R8: A go write while idle with a count of 0 sets done and irq on the next cycle and never raises bus_req.
- R9: A write to the status register clears done and irq, and so does any accepted go write. If a clear falls on the same edge as a completion, done stays set.
- R10: A grant with no request has no effect. While busy, writes to selects 0 to 3 and further go writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_sel |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_en | output | 1 | Memory transfer strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |
| dev_addr | output | DEV_W | Device port address |
| dev_rd | output | 1 | Device read strobe |
| dev_rdata | input | DATA_W | Device read data, same cycle |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | DATA_W | Device write data |
| irq | output | 1 | Completion interrupt, level |

## Verification
A status-register clear can land on the same edge on which the last word completes, and only one of the two can win the done flag. The bench waits until its reference model shows the final transfer cycle under way. It then drives the status write so that the write is sampled on that same completion edge. It judges the result by irq and the status readback, which must still show done set. A second overlap comes from a zero-count go write issued while done is still high: the clear and the set coincide, and done must end set.

// File: rtl/dma_steal_pkg.sv
// Package: shared state type and register-window encoding for the
// cycle-stealing DMA engine. Assumes a 3-bit register select.
package dma_steal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2,
        ST_REL  = 2'd3
    } xfer_state_t;

    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_DEV  = 3'd1;
    localparam logic [2:0] SEL_MEM  = 3'd2;
    localparam logic [2:0] SEL_CNT  = 3'd3;
    localparam logic [2:0] SEL_STAT = 3'd4;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_DIR_BIT  = 1;
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_DONE_BIT = 1;

endpackage

// File: rtl/dma_steal_regs.sv
// Module: programming registers, live address/count and done flag.
// Assumes: step_i pulses once per moved word; loads are refused while busy.
module dma_steal_regs
    import dma_steal_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 16,
    parameter int DEV_W      = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy_i,
    input  logic              step_i,
    input  logic              last_i,
    output logic              go_o,
    output logic              dir_o,
    output logic [DEV_W-1:0]  dev_addr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              cnt_zero_o,
    output logic              cnt_one_o,
    output logic              done_o
);

    localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    logic              dir_q;
    logic [DEV_W-1:0]  dev_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              load_ok;
    logic              clr_done;

    // Decode an accepted load, go command and done clear.
    always_comb begin
        load_ok  = reg_we && !busy_i;
        go_o     = load_ok && (reg_sel == SEL_CTRL) && reg_wdata[CTRL_GO_BIT];
        clr_done = (reg_we && (reg_sel == SEL_STAT)) || go_o;
    end

    // Hold direction and device address loaded while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            dev_q <= '0;
        end else if (load_ok) begin
            if (reg_sel == SEL_CTRL) dir_q <= reg_wdata[CTRL_DIR_BIT];
            if (reg_sel == SEL_DEV)  dev_q <= DEV_W'(reg_wdata);
        end
    end

    // Memory address: software load when idle, one word step per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (step_i) begin
            addr_q <= addr_q + ADDR_INC;
        end else if (load_ok && (reg_sel == SEL_MEM)) begin
            addr_q <= ADDR_W'(reg_wdata);
        end
    end

    // Word count: software load when idle, decrement per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q - CNT_ONE;
        end else if (load_ok && (reg_sel == SEL_CNT)) begin
            cnt_q <= CNT_W'(reg_wdata);
        end
    end

    // Done flag: completion sets and wins over any clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (last_i || (go_o && cnt_zero_o)) begin
            done_q <= 1'b1;
        end else if (clr_done) begin
            done_q <= 1'b0;
        end
    end

    // Same-cycle register readback.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: reg_rdata[CTRL_DIR_BIT] = dir_q;
            SEL_DEV:  reg_rdata = DATA_W'(dev_q);
            SEL_MEM:  reg_rdata = DATA_W'(addr_q);
            SEL_CNT:  reg_rdata = DATA_W'(cnt_q);
            SEL_STAT: begin
                reg_rdata[STAT_BUSY_BIT] = busy_i;
                reg_rdata[STAT_DONE_BIT] = done_q;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign dir_o      = dir_q;
    assign dev_addr_o = dev_q;
    assign mem_addr_o = addr_q;
    assign cnt_zero_o = (cnt_q == '0);
    assign cnt_one_o  = (cnt_q == CNT_ONE);
    assign done_o     = done_q;

    // R6: count falls by one per moved word.
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> cnt_q == $past(cnt_q) - CNT_ONE);

    // R6: address grows by one word per moved word.
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> addr_q == $past(addr_q) + ADDR_INC);

    // R7: the final word always leaves done set.
    p_done_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_i |=> done_q);

    // R10: a busy engine keeps its programmed direction and device.
    p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(dir_q) && $stable(dev_q));

endmodule

// File: rtl/dma_steal_fsm.sv
// Module: per-word request/grant sequencer.
// Assumes: the arbiter keeps bus_gnt high while bus_req stays high.
module dma_steal_fsm
    import dma_steal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic cnt_zero_i,
    input  logic cnt_one_i,
    input  logic bus_gnt,
    output logic bus_req,
    output logic busy_o,
    output logic xfer_o,
    output logic last_o
);

    xfer_state_t state_q;
    xfer_state_t state_d;

    // Next state: request, one-word transfer, release, repeat.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (go_i && !cnt_zero_i) state_d = ST_REQ;
            ST_REQ:  if (bus_gnt) state_d = ST_XFER;
            ST_XFER: state_d = cnt_one_i ? ST_IDLE : ST_REL;
            ST_REL:  state_d = ST_REQ;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign bus_req = (state_q == ST_REQ) || (state_q == ST_XFER);
    assign busy_o  = (state_q != ST_IDLE);
    assign xfer_o  = (state_q == ST_XFER);
    assign last_o  = xfer_o && cnt_one_i;

    // R4: a transfer cycle follows a granted request.
    p_xfer_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |-> $past(bus_req && bus_gnt));

    // R5: the request falls right after each word.
    p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> !bus_req);

    // R8: a zero-count go never requests the bus.
    p_zero_no_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && cnt_zero_i && !busy_o) |=> !bus_req);

    // R3: a nonzero go raises the request next cycle.
    p_go_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !cnt_zero_i && !busy_o) |=> bus_req);

endmodule

// File: rtl/dma_steal_port.sv
// Module: steers one word between device port and memory bus.
// Assumes: both sides return read data in the same cycle as the strobe.
module dma_steal_port #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEV_W  = 8
) (
    input  logic              xfer_i,
    input  logic              dir_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DEV_W-1:0]  dev_i,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DEV_W-1:0]  dev_addr,
    output logic              dev_rd,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_wr,
    output logic [DATA_W-1:0] dev_wdata
);

    // Strobes follow the direction; data paths pass straight across.
    always_comb begin
        mem_en    = xfer_i;
        mem_we    = xfer_i && !dir_i;
        dev_rd    = xfer_i && !dir_i;
        dev_wr    = xfer_i && dir_i;
        mem_addr  = addr_i;
        dev_addr  = dev_i;
        mem_wdata = dev_rdata;
        dev_wdata = mem_rdata;
    end

    // R4: never both device strobes in one cycle.
    always_comb begin
        p_one_dev_strobe_r4: assert ($onehot0({dev_rd, dev_wr}));
    end

endmodule

// File: rtl/dma_steal_engine.sv
// Module: top of the cycle-stealing DMA engine.
// Moves one word per bus grant and raises irq after the last word.
// Assumes: a single device port and a word-addressed byte bus.
module dma_steal_engine #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 16,
    parameter int DEV_W      = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DEV_W-1:0]  dev_addr,
    output logic              dev_rd,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_wr,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              irq
);

    logic              go;
    logic              dir;
    logic [DEV_W-1:0]  dev_q;
    logic [ADDR_W-1:0] addr_q;
    logic              cnt_zero;
    logic              cnt_one;
    logic              done;
    logic              busy;
    logic              xfer;
    logic              last;

    dma_steal_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .DEV_W(DEV_W), .WORD_BYTES(WORD_BYTES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy_i(busy), .step_i(xfer), .last_i(last),
        .go_o(go), .dir_o(dir), .dev_addr_o(dev_q), .mem_addr_o(addr_q),
        .cnt_zero_o(cnt_zero), .cnt_one_o(cnt_one), .done_o(done)
    );

    dma_steal_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .go_i(go), .cnt_zero_i(cnt_zero), .cnt_one_i(cnt_one),
        .bus_gnt(bus_gnt), .bus_req(bus_req),
        .busy_o(busy), .xfer_o(xfer), .last_o(last)
    );

    dma_steal_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_W(DEV_W)
    ) u_port (
        .xfer_i(xfer), .dir_i(dir), .addr_i(addr_q), .dev_i(dev_q),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_addr(dev_addr), .dev_rd(dev_rd), .dev_rdata(dev_rdata),
        .dev_wr(dev_wr), .dev_wdata(dev_wdata)
    );

    assign irq = done;

    // R7: irq and busy are never high together after the last word.
    p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> irq && !busy);

endmodule

// File: tb/tb_dma_steal_engine.sv
// Bench: behavioural reference model compared with the engine every cycle.
module tb_dma_steal_engine;

    localparam logic [31:0] MEM_KEY = 32'hC3C3_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        mem_en, mem_we, dev_rd, dev_wr, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, dev_rdata, dev_wdata;
    logic [7:0]  dev_addr;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit chk_on = 0;
    int gnt_delay = 0;
    int gnt_wait = 0;
    bit gnt_force = 0;
    int req_seen = 0;

    // reference model state
    int          m_phase = 0;   // 0 idle, 1 request, 2 transfer, 3 release
    logic [31:0] m_addr = '0;
    int          m_cnt = 0;
    bit          m_done = 0;
    bit          m_dir = 0;
    logic [7:0]  m_dev = '0;

    always #10 clk = ~clk;

    dma_steal_engine dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_addr(dev_addr), .dev_rd(dev_rd), .dev_rdata(dev_rdata),
        .dev_wr(dev_wr), .dev_wdata(dev_wdata), .irq(irq)
    );

    assign mem_rdata = mem_addr ^ MEM_KEY;

    // device data changes every cycle
    initial dev_rdata = 32'h1000_0000;
    always @(posedge clk) dev_rdata <= dev_rdata + 32'h0101_0101;

    // arbiter: grant after gnt_delay cycles of request, or forced
    always @(posedge clk) begin
        if (bus_req) gnt_wait <= gnt_wait + 1;
        else         gnt_wait <= 0;
        bus_gnt <= gnt_force || (bus_req && gnt_wait >= gnt_delay);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // reference model update on each edge
    always @(posedge clk) begin
        bit busy, go, last;
        if (!rst_n) begin
            m_phase = 0; m_addr = '0; m_cnt = 0; m_done = 0; m_dir = 0; m_dev = '0;
        end else begin
            busy = (m_phase != 0);
            go   = reg_we && reg_sel == 3'd0 && reg_wdata[0] && !busy;
            last = (m_phase == 2) && (m_cnt == 1);
            if (last || (go && m_cnt == 0)) m_done = 1;
            else if (reg_we && (reg_sel == 3'd4 || go)) m_done = 0;
            if (reg_we && !busy) begin
                case (reg_sel)
                    3'd0: m_dir = reg_wdata[1];
                    3'd1: m_dev = reg_wdata[7:0];
                    3'd2: m_addr = reg_wdata;
                    3'd3: m_cnt = int'(reg_wdata[15:0]);
                    default: ;
                endcase
            end
            case (m_phase)
                0: if (go && m_cnt != 0) m_phase = 1;
                1: if (bus_gnt) m_phase = 2;
                2: begin
                    m_addr = m_addr + 32'd4;
                    m_cnt  = m_cnt - 1;
                    m_phase = last ? 0 : 3;
                end
                default: m_phase = 1;
            endcase
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        bit xf;
        if (chk_on) begin
            xf = (m_phase == 2);
            chk("R5 bus_req", {31'd0, bus_req}, {31'd0, (m_phase == 1 || m_phase == 2)});
            chk("R4 mem_en", {31'd0, mem_en}, {31'd0, xf});
            chk("R4 mem_we", {31'd0, mem_we}, {31'd0, xf && !m_dir});
            chk("R4 dev_rd", {31'd0, dev_rd}, {31'd0, xf && !m_dir});
            chk("R4 dev_wr", {31'd0, dev_wr}, {31'd0, xf && m_dir});
            chk("R7 irq", {31'd0, irq}, {31'd0, m_done});
            if (xf) begin
                chk("R6 mem_addr", mem_addr, m_addr);
                chk("R4 dev_addr", {24'd0, dev_addr}, {24'd0, m_dev});
                if (!m_dir) chk("R4 mem_wdata", mem_wdata, dev_rdata);
                else        chk("R4 dev_wdata", dev_wdata, m_addr ^ MEM_KEY);
            end
            case (reg_sel)
                3'd0: exp_rd = {30'd0, m_dir, 1'b0};
                3'd1: exp_rd = {24'd0, m_dev};
                3'd2: exp_rd = m_addr;
                3'd3: exp_rd = 32'(m_cnt);
                3'd4: exp_rd = {30'd0, m_done, (m_phase != 0)};
                default: exp_rd = '0;
            endcase
            chk("R2 reg_rdata", reg_rdata, exp_rd);
            if (bus_req) req_seen++;
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
        @(posedge clk); #1;
        reg_sel = sel;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wait_idle();
        while (m_phase != 0) @(negedge clk);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_err++;
            $display("FAIL R7 watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_on = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
        rd_chk("R1 status after reset", 3'd4, 32'd0);
        rd_chk("R1 count after reset", 3'd3, 32'd0);

        // R10: grant without request does nothing
        gnt_force = 1;
        repeat (4) @(negedge clk);
        chk("R10 no request on stray grant", {31'd0, bus_req}, 32'd0);
        gnt_force = 0;

        // device to memory, three words, slow grant
        gnt_delay = 2;
        wr(3'd1, 32'h0000_003C);
        wr(3'd2, 32'h0000_1000);
        wr(3'd3, 32'd3);
        rd_chk("R2 device address readback", 3'd1, 32'h3C);
        req_seen = 0;
        wr(3'd0, 32'h1);
        @(negedge clk);
        chk("R3 request after go", {31'd0, bus_req}, 32'd1);
        wait_idle();
        rd_chk("R6 final address", 3'd2, 32'h0000_100C);
        rd_chk("R6 final count", 3'd3, 32'd0);
        rd_chk("R7 done set, busy clear", 3'd4, 32'h2);
        wr(3'd4, 32'h0);
        @(negedge clk);
        chk("R9 irq cleared by status write", {31'd0, irq}, 32'd0);

        // memory to device, four words, immediate grant, busy writes ignored
        gnt_delay = 0;
        wr(3'd2, 32'h0000_2000);
        wr(3'd3, 32'd4);
        wr(3'd0, 32'h3);
        wr(3'd2, 32'h0000_FFF0);
        wr(3'd1, 32'h0000_0077);
        wr(3'd0, 32'h1);
        wait_idle();
        rd_chk("R10 address not reloaded while busy", 3'd2, 32'h0000_2010);
        rd_chk("R10 device not reloaded while busy", 3'd1, 32'h3C);
        rd_chk("R2 direction readback", 3'd0, 32'h2);

        // R8: zero count, done still set (start also clears and sets)
        req_seen = 0;
        wr(3'd0, 32'h1);
        @(negedge clk);
        chk("R8 irq after zero-count go", {31'd0, irq}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R8 no bus activity", 32'(req_seen), 32'd0);

        // R9: status clear on the completion edge
        wr(3'd4, 32'h0);
        gnt_delay = 1;
        wr(3'd3, 32'd2);
        wr(3'd0, 32'h1);
        while (!(m_phase == 2 && m_cnt == 1)) @(negedge clk);
        reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = '0;
        @(posedge clk); #1;
        reg_we = 1'b0;
        @(negedge clk);
        chk("R9 completion wins over clear", {31'd0, irq}, 32'd1);
        chk("R9 status shows done", reg_rdata, 32'h2);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule